// File: doc/BRIEF.md
# PCM Highway Timeslot Port

This block moves one 8-bit sample per frame in each direction over a serial PCM highway. The highway bit clock, `pclk`, is the block's only clock. A frame begins when `fsync` is seen to go from low to high. From that point the port counts bit clocks. It drives its transmit byte onto `dtx` at one programmed offset and collects a receive byte from `drx` at a second, independent offset. Because only the rising edge of `fsync` matters, both single-clock and long frame-sync pulses work. An offset of zero places the most significant bit in the cycle of the frame-sync edge itself.

On the parallel side, a sample is written into a holding register with `tx_load`. That register is copied into the frame at each frame start. A received byte appears on `rx_sample` with a one-cycle `rx_valid` pulse. A 3-bit length select sets the frame length to 32 << sel bit clocks, which gives 4 to 128 timeslots. Positions at or beyond the frame length are never used. If no new frame-sync edge arrives, the port falls silent rather than wrapping into a new frame.

The sequencer has three states:
- ST_OFF: the port is disabled.
- ST_HUNT: the port is enabled and waits for a frame-sync edge.
- ST_RUN: the port is counting bit positions inside a frame.

Its transitions are:
- enable: ST_OFF to ST_HUNT.
- disable: any state to ST_OFF.
- frame start: an FSYNC rise, from any enabled state, to ST_RUN with the position reset to 0.
- frame expiry: ST_RUN to ST_HUNT after the last position of the frame.

Top module: `pcm_hwy_port`

## Requirements
- R1: After reset, `dtx_oe` is 0, `rx_valid` is 0 and `rx_sample` is 0.
- R2: A frame starts only at a `pclk` rising edge where `fsync` is 1 and was 0 at the previous edge. How long `fsync` stays high has no effect.
- R3: The cycle after the frame-start edge is position 0. The transmit MSB is driven in position `tx_start`. So with `tx_start` = 0 the MSB appears right after the edge that samples the FSYNC rise.
- R4: `dtx` carries the byte MSB first, one bit per cycle, over 8 consecutive positions. `dtx_oe` is 1 in exactly those cycles and 0 otherwise.
- R5: `drx` is sampled on the falling `pclk` edge of positions `rx_start` to `rx_start`+7. The first sample is the MSB.
- R6: `rx_valid` pulses for one cycle, right after the cycle of the eighth receive bit. `rx_sample` changes only with that pulse.
- R7: The frame length is 32 << `len_sel` cycles. Values of `len_sel` above 5 act as 5 (1024 cycles). Positions at or past the frame length drive nothing and sample nothing. A byte cut off by the frame end gives no `rx_valid`. Without a new FSYNC rise, the port stays quiet and does not wrap.
- R8: An FSYNC rise before the frame end restarts positions at 0. Any partly received byte is dropped.
- R9: The byte sent in a frame is the holding-register value from before the frame-start edge. A `tx_load` at that same edge only affects later frames.
- R10: While `port_en` is 0, `dtx_oe` and `rx_valid` stay 0. After enable returns, nothing is driven or sampled until the next FSYNC rise.
- R11: The transmit and receive offsets are independent, so the two directions may sit in different timeslots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Highway bit clock |
| rst | input | 1 | Synchronous reset, active high |
| port_en | input | 1 | Port enable |
| len_sel | input | 3 | Frame length select, 32 << sel cycles |
| tx_start | input | 10 | Transmit offset in bit clocks |
| rx_start | input | 10 | Receive offset in bit clocks |
| fsync | input | 1 | Frame sync |
| drx | input | 1 | Serial receive data |
| dtx | output | 1 | Serial transmit data |
| dtx_oe | output | 1 | Transmit output enable |
| tx_sample | input | 8 | Parallel transmit sample |
| tx_load | input | 1 | Load strobe for `tx_sample` |
| rx_sample | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse on a new received byte |

## Verification
On every cycle, the assertions check four properties:
- a frame start is never taken while FSYNC was already high;
- the transmit enable never stays high longer than one byte;
- a receive pulse never lasts two cycles, and the received byte never moves without one;
- a disabled port neither drives nor reports.

Other behaviours can only be shown by the bench's scenarios, which compare against a behavioural model on every clock:
- the exact bit placement for a given offset;
- the MSB-first order;
- truncation at the frame end;
- the silence after frame expiry;
- the restart on an early FSYNC;
- which held sample a frame carries.

// File: rtl/pcm_hwy_pkg.sv
package pcm_hwy_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HUNT = 2'd1,
        ST_RUN  = 2'd2
    } frm_state_t;
endpackage

// File: rtl/pcm_frame_ctl.sv
module pcm_frame_ctl
    import pcm_hwy_pkg::*;
#(
    parameter int SEL_W    = 3,
    parameter int MAX_SEL  = 5,
    parameter int BASE_LOG = 5,
    parameter int POS_W    = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             fsync,
    input  logic [SEL_W-1:0] len_sel,
    output logic             frame_start,
    output logic             pos_vld,
    output logic [POS_W-1:0] pos
);
    frm_state_t       state_q, state_d;
    logic             fsync_q;
    logic             rise;
    logic [POS_W-1:0] cnt_q;
    logic [SEL_W-1:0] sel_eff;
    logic [POS_W-1:0] frame_len;
    logic [POS_W-1:0] last_pos;

    assign rise      = en && fsync && !fsync_q;
    assign sel_eff   = (len_sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : len_sel;
    assign frame_len = POS_W'(1) << (BASE_LOG + int'(sel_eff));
    assign last_pos  = frame_len - POS_W'(1);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_OFF;
        end else if (rise) begin
            state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_HUNT;
                ST_HUNT: state_d = ST_HUNT;
                ST_RUN:  state_d = (cnt_q >= last_pos) ? ST_HUNT : ST_RUN;
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OFF;
        else     state_q <= state_d;
    end

    // position counter and frame-sync history
    always_ff @(posedge clk) begin
        if (rst) begin
            fsync_q <= 1'b1;
            cnt_q   <= '0;
        end else begin
            fsync_q <= fsync;
            if (rise)                  cnt_q <= POS_W'(1);
            else if (state_q == ST_RUN) cnt_q <= cnt_q + POS_W'(1);
        end
    end

    // outputs
    always_comb begin
        frame_start = rise;
        pos         = rise ? '0 : cnt_q;
        pos_vld     = rise || (state_q == ST_RUN && en && cnt_q < frame_len);
    end
endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot #(
    parameter int CNT_W     = 10,
    parameter int POS_W     = 11,
    parameter int SLOT_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_start,
    input  logic                 pos_vld,
    input  logic [POS_W-1:0]     pos,
    input  logic [CNT_W-1:0]     tx_start,
    input  logic [SLOT_BITS-1:0] tx_sample,
    input  logic                 tx_load,
    output logic                 dtx,
    output logic                 dtx_oe
);
    localparam int IDX_W = $clog2(SLOT_BITS);

    logic [SLOT_BITS-1:0] hold_q, frame_q, src;
    logic [POS_W-1:0]     off;
    logic [IDX_W-1:0]     bit_idx;
    logic                 in_win;

    assign off     = pos - POS_W'(tx_start);
    assign in_win  = pos_vld && (pos >= POS_W'(tx_start)) && (off < POS_W'(SLOT_BITS));
    assign src     = frame_start ? hold_q : frame_q;
    assign bit_idx = IDX_W'(SLOT_BITS - 1) - off[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            frame_q <= '0;
            dtx     <= 1'b0;
            dtx_oe  <= 1'b0;
        end else begin
            if (frame_start) frame_q <= hold_q;
            if (tx_load)     hold_q  <= tx_sample;
            dtx_oe <= in_win;
            dtx    <= in_win ? src[bit_idx] : 1'b0;
        end
    end
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot #(
    parameter int CNT_W     = 10,
    parameter int POS_W     = 11,
    parameter int SLOT_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 pos_vld,
    input  logic [POS_W-1:0]     pos,
    input  logic [CNT_W-1:0]     rx_start,
    input  logic                 drx,
    output logic [SLOT_BITS-1:0] rx_sample,
    output logic                 rx_valid
);
    localparam int IDX_W = $clog2(SLOT_BITS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOT_BITS - 1);

    logic                 drx_s;
    logic                 win_q;
    logic [IDX_W-1:0]     idx_q;
    logic [SLOT_BITS-1:0] sh_q, shifted;
    logic [POS_W-1:0]     off;
    logic                 in_win;
    logic                 done;

    assign off     = pos - POS_W'(rx_start);
    assign in_win  = pos_vld && (pos >= POS_W'(rx_start)) && (off < POS_W'(SLOT_BITS));
    assign shifted = {sh_q[SLOT_BITS-2:0], drx_s};
    assign done    = win_q && (idx_q == LAST) && en;

    // mid-bit sample of the serial input
    always_ff @(negedge clk) begin
        drx_s <= drx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q     <= 1'b0;
            idx_q     <= '0;
            sh_q      <= '0;
            rx_sample <= '0;
            rx_valid  <= 1'b0;
        end else begin
            if (win_q) sh_q <= shifted;
            if (done)  rx_sample <= shifted;
            rx_valid <= done;
            win_q    <= in_win;
            idx_q    <= off[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/pcm_hwy_port.sv
module pcm_hwy_port #(
    parameter int CNT_W     = 10,
    parameter int SEL_W     = 3,
    parameter int MAX_SEL   = 5,
    parameter int BASE_LOG  = 5,
    parameter int SLOT_BITS = 8
) (
    input  logic                 pclk,
    input  logic                 rst,
    input  logic                 port_en,
    input  logic [SEL_W-1:0]     len_sel,
    input  logic [CNT_W-1:0]     tx_start,
    input  logic [CNT_W-1:0]     rx_start,
    input  logic                 fsync,
    input  logic                 drx,
    output logic                 dtx,
    output logic                 dtx_oe,
    input  logic [SLOT_BITS-1:0] tx_sample,
    input  logic                 tx_load,
    output logic [SLOT_BITS-1:0] rx_sample,
    output logic                 rx_valid
);
    localparam int POS_W = BASE_LOG + MAX_SEL + 1;

    logic             frame_start;
    logic             pos_vld;
    logic [POS_W-1:0] pos;

    pcm_frame_ctl #(
        .SEL_W(SEL_W), .MAX_SEL(MAX_SEL), .BASE_LOG(BASE_LOG), .POS_W(POS_W)
    ) u_ctl (
        .clk(pclk), .rst(rst), .en(port_en), .fsync(fsync), .len_sel(len_sel),
        .frame_start(frame_start), .pos_vld(pos_vld), .pos(pos)
    );

    pcm_tx_slot #(
        .CNT_W(CNT_W), .POS_W(POS_W), .SLOT_BITS(SLOT_BITS)
    ) u_tx (
        .clk(pclk), .rst(rst), .frame_start(frame_start), .pos_vld(pos_vld),
        .pos(pos), .tx_start(tx_start), .tx_sample(tx_sample), .tx_load(tx_load),
        .dtx(dtx), .dtx_oe(dtx_oe)
    );

    pcm_rx_slot #(
        .CNT_W(CNT_W), .POS_W(POS_W), .SLOT_BITS(SLOT_BITS)
    ) u_rx (
        .clk(pclk), .rst(rst), .en(port_en), .pos_vld(pos_vld), .pos(pos),
        .rx_start(rx_start), .drx(drx), .rx_sample(rx_sample), .rx_valid(rx_valid)
    );
endmodule

// File: rtl/pcm_hwy_port_chk.sv
module pcm_hwy_port_chk #(
    parameter int SLOT_BITS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 en,
    input logic                 fsync,
    input logic                 frame_start,
    input logic                 dtx_oe,
    input logic                 rx_valid,
    input logic [SLOT_BITS-1:0] rx_sample
);
    logic [15:0] oe_run;

    always_ff @(posedge clk) begin
        if (rst)         oe_run <= '0;
        else if (dtx_oe) oe_run <= (oe_run == 16'hFFFF) ? oe_run : oe_run + 16'd1;
        else             oe_run <= '0;
    end

    // R2
    edge_only_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> !$past(fsync));

    // R4
    oe_len_chk: assert property (@(posedge clk) disable iff (rst)
        dtx_oe |-> (oe_run < 16'(SLOT_BITS)));

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_sample));

    // R10
    quiet_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!dtx_oe && !rx_valid));
endmodule

bind pcm_hwy_port pcm_hwy_port_chk #(.SLOT_BITS(SLOT_BITS)) u_chk (
    .clk(pclk), .rst(rst), .en(port_en), .fsync(fsync), .frame_start(frame_start),
    .dtx_oe(dtx_oe), .rx_valid(rx_valid), .rx_sample(rx_sample)
);

// File: tb/sim_pcm_hwy_port.sv
module sim_pcm_hwy_port;
    localparam int CLK_NS = 10;

    logic       pclk = 1'b0;
    logic       rst = 1'b1;
    logic       port_en = 1'b0;
    logic [2:0] len_sel = 3'd0;
    logic [9:0] tx_start = '0;
    logic [9:0] rx_start = '0;
    logic       fsync = 1'b0;
    logic       drx = 1'b0;
    logic       dtx, dtx_oe;
    logic [7:0] tx_sample = '0;
    logic       tx_load = 1'b0;
    logic [7:0] rx_sample;
    logic       rx_valid;

    int    total = 0;
    int    bad = 0;
    string cur_tag = "R1";
    int    cnt_oe = 0;
    int    cnt_val = 0;
    int    cnt_oe_off = 0;
    logic  count_off = 1'b0;
    logic [7:0] tx_seen = '0;
    logic  done = 1'b0;

    always #(CLK_NS/2) pclk = ~pclk;

    pcm_hwy_port u0 (
        .pclk(pclk), .rst(rst), .port_en(port_en), .len_sel(len_sel),
        .tx_start(tx_start), .rx_start(rx_start), .fsync(fsync), .drx(drx),
        .dtx(dtx), .dtx_oe(dtx_oe), .tx_sample(tx_sample), .tx_load(tx_load),
        .rx_sample(rx_sample), .rx_valid(rx_valid)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // serial receive stimulus
    logic [15:0] lfsr = 16'hACE1;
    always @(posedge pclk) begin
        #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        drx = lfsr[0];
    end

    // behavioural reference model
    logic       m_drx;
    logic       prev_fs;
    logic       live;
    int         since;
    logic [7:0] m_hold, m_frame, m_sh, e_data;
    int         ridx;
    logic       e_oe, e_dtx, e_valid;

    always @(negedge pclk) m_drx = drx;

    always @(posedge pclk) begin
        if (rst) begin
            prev_fs = 1'b1; live = 1'b0; since = 0;
            m_hold = '0; m_frame = '0; m_sh = '0; e_data = '0;
            ridx = -1; e_oe = 1'b0; e_dtx = 1'b0; e_valid = 1'b0;
        end else begin
            int  flen, p;
            logic rise;
            rise = fsync && !prev_fs && port_en;
            prev_fs = fsync;
            flen = 32 << ((len_sel > 3'd5) ? 5 : int'(len_sel));
            if (!port_en) live = 1'b0;
            if (rise) begin
                live = 1'b1; since = 0; m_frame = m_hold;
            end else if (live) begin
                since++;
            end
            if (live && since >= flen) live = 1'b0;
            p = live ? since : -1;
            e_valid = 1'b0;
            if (ridx >= 0) begin
                m_sh = {m_sh[6:0], m_drx};
                if (ridx == 7 && port_en) begin
                    e_valid = 1'b1; e_data = m_sh;
                end
            end
            ridx = (p >= 0 && p >= int'(rx_start) && p < int'(rx_start) + 8) ? p - int'(rx_start) : -1;
            if (p >= 0 && p >= int'(tx_start) && p < int'(tx_start) + 8) begin
                e_oe = 1'b1; e_dtx = m_frame[7 - (p - int'(tx_start))];
            end else begin
                e_oe = 1'b0; e_dtx = 1'b0;
            end
            if (tx_load) m_hold = tx_sample;
        end
    end

    // per-cycle comparison, away from the edge
    always @(posedge pclk) begin
        #7;
        if (!rst && !done) begin
            chk(cur_tag, "dtx_oe", dtx_oe, e_oe);
            if (e_oe) chk(cur_tag, "dtx", dtx, e_dtx);
            chk(cur_tag, "rx_valid", rx_valid, e_valid);
            if (e_valid) chk(cur_tag, "rx_sample", rx_sample, e_data);
            if (dtx_oe) begin
                cnt_oe++;
                tx_seen = {tx_seen[6:0], dtx};
            end
            if (rx_valid) cnt_val++;
            if (count_off && (dtx_oe || rx_valid)) cnt_oe_off++;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge pclk);
            #2;
        end
    endtask

    task automatic clear_counts();
        cnt_oe = 0; cnt_val = 0; cnt_oe_off = 0;
    endtask

    task automatic frames(input int nfr, input int flen, input int hi);
        for (int f = 0; f < nfr; f++) begin
            tx_sample = 8'h3C ^ 8'(f * 37 + flen);
            tx_load = 1'b1;
            tick(1);
            tx_load = 1'b0;
            fsync = 1'b1;
            tick(hi);
            fsync = 1'b0;
            tick(flen - hi - 1);
        end
    endtask

    initial begin
        #(CLK_NS * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(2);
        // R1: reset state
        chk("R1", "dtx_oe", dtx_oe, 1'b0);
        chk("R1", "rx_valid", rx_valid, 1'b0);
        chk("R1", "rx_sample", rx_sample, 8'h00);

        // R3 R4 R5 R6: offset 0 transmit, short pulses, 32-cycle frames
        cur_tag = "R3/R4/R5/R6";
        port_en = 1'b1; len_sel = 3'd0; tx_start = 10'd0; rx_start = 10'd5;
        tick(2); clear_counts();
        frames(3, 32, 1);
        tick(3);
        chk("R4", "oe cycles", cnt_oe, 24);
        chk("R6", "valid pulses", cnt_val, 3);

        // R2 R11: long pulse, separate slots, 64-cycle frames
        cur_tag = "R2/R11";
        len_sel = 3'd1; tx_start = 10'd20; rx_start = 10'd3;
        clear_counts();
        frames(2, 64, 10);
        tick(3);
        chk("R2", "oe cycles", cnt_oe, 16);
        chk("R11", "valid pulses", cnt_val, 2);

        // R7: truncated bytes at frame end, then offset beyond frame
        cur_tag = "R7";
        len_sel = 3'd0; tx_start = 10'd30; rx_start = 10'd28;
        clear_counts();
        frames(2, 32, 1);
        tick(40);
        chk("R7", "truncated oe", cnt_oe, 4);
        chk("R7", "truncated valid", cnt_val, 0);
        tx_start = 10'd40; rx_start = 10'd33;
        clear_counts();
        frames(1, 32, 1);
        tick(40);
        chk("R7", "beyond-frame oe", cnt_oe, 0);
        chk("R7", "beyond-frame valid", cnt_val, 0);

        // R7: single frame-sync, no wrap afterwards
        tx_start = 10'd4; rx_start = 10'd4;
        clear_counts();
        frames(1, 32, 1);
        tick(100);
        chk("R7", "no-wrap oe", cnt_oe, 8);
        chk("R7", "no-wrap valid", cnt_val, 1);

        // R8: early frame-sync mid-byte
        cur_tag = "R8";
        len_sel = 3'd2; tx_start = 10'd12; rx_start = 10'd12;
        clear_counts();
        frames(1, 14, 1);
        frames(1, 128, 1);
        tick(5);
        chk("R8", "restart oe", cnt_oe, 10);
        chk("R8", "restart valid", cnt_val, 1);

        // R9: load at the frame-start edge
        cur_tag = "R9";
        len_sel = 3'd0; tx_start = 10'd0; rx_start = 10'd16;
        tx_sample = 8'hC3; tx_load = 1'b1;
        tick(1);
        tx_load = 1'b0;
        tick(2);
        fsync = 1'b1; tx_sample = 8'h5A; tx_load = 1'b1;
        tick(1);
        fsync = 1'b0; tx_load = 1'b0;
        tick(31);
        chk("R9", "sent byte", tx_seen, 8'hC3);
        fsync = 1'b1;
        tick(1);
        fsync = 1'b0;
        tick(31);
        chk("R9", "next byte", tx_seen, 8'h5A);

        // R10: disable mid-frame, re-enable without frame-sync
        cur_tag = "R10";
        tx_start = 10'd8; rx_start = 10'd8;
        fsync = 1'b1;
        tick(1);
        fsync = 1'b0;
        tick(9);
        port_en = 1'b0;
        tick(1);
        count_off = 1'b1;
        tick(5);
        count_off = 1'b0;
        chk("R10", "activity while off", cnt_oe_off, 0);
        port_en = 1'b1;
        clear_counts();
        tick(40);
        chk("R10", "oe before next sync", cnt_oe, 0);
        frames(1, 32, 1);
        tick(3);
        chk("R10", "oe after sync", cnt_oe, 8);

        // R7: length select above 5 clamps to 1024
        cur_tag = "R7";
        len_sel = 3'd7; tx_start = 10'd1000; rx_start = 10'd1016;
        clear_counts();
        frames(2, 1024, 1);
        tick(3);
        chk("R7", "clamped oe", cnt_oe, 16);
        chk("R7", "clamped valid", cnt_val, 2);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule